// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave port that lets a host processor set up a transmitter core through a small register file. The host lowers a chip select and clocks in 16-bit words, most significant bit first. Each word holds a 2-bit device match field, a direction flag, a 5-bit register address and one data byte. A write takes effect when the chip select rises, and only if the word was complete. A read drives the addressed byte on a serial output during the last eight bit periods of the same word. The output has a separate driver enable, so the pad can be high-impedance whenever the port is not answering.

All serial inputs are synchronised into the system clock domain and their edges are found there. The register fields come out as ports to the rest of the core: the audio input format, the power and run controls, the reduced-port mode and the source select, the sample-invalid flag and transmit enable, and a 42-bit channel-status vector. When one stored bit selects the reduced port mode, reads are refused and the output enable stays low. The port then takes writes only. The system reset, which stands for the power-down pin, returns every register to its default.

Top module: `ctlp_port`

## Requirements
- R1: A word is accepted only when its first two bits are 2'b11. A word with any other value there changes no register and never raises `sdo_oe`.
- R2: A write (third bit = 1) commits when `cs_n` rises, and only if at least 16 rising `sclk` edges came while `cs_n` was low. A word cut short changes nothing.
- R3: A read (third bit = 0) in normal mode drives the addressed byte on `sdo`, MSB first. Each bit is launched on a falling `sclk` edge, starting with the falling edge after the eighth rising edge. `sdo_oe` first rises with that edge.
- R4: `sdo_oe` is low while `cs_n` is high and during the first eight bit periods of every word.
- R5: When address 02h bit 2 (`three_wire`) is 1, read words are ignored and `sdo_oe` stays low. Write words still commit.
- R6: Reset values: 00h = 8'h0F (bits 3:2 `link_fmt` = 2'b11, bit 1 `pwr_up` = 1, bit 0 `core_run` = 1); 02h = 8'h00 (bit 2 `three_wire`, bits 1:0 `src_sel`); 03h = 8'h01 (bit 1 `smp_invalid`, bit 0 `tx_en` = 1); 04h = 8'h04; 05h to 09h = 8'h00.
- R7: Address 01h and addresses 0Ah to 1Fh read as 8'h00, and writes to them are ignored.
- R8: Bits a register does not implement read as 0 and are dropped on write. Only bits 1:0 of 09h are stored. `chan_stat[8*k+i]` is bit i of address 04h+k.
- R9: Rising `sclk` edges after the sixteenth in one select period are ignored, and the first 16 bits still commit.
- R10: Register outputs change only on a committed write or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-down) |
| sclk | input | 1 | Host serial clock |
| cs_n | input | 1 | Host chip select, active low |
| sdi | input | 1 | Host serial data in |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Driver enable for `sdo`; low means high-impedance |
| link_fmt | output | 2 | Audio input format select |
| pwr_up | output | 1 | Power control bit |
| core_run | output | 1 | Run (not held in reset) control bit |
| three_wire | output | 1 | Reduced write-only port mode |
| src_sel | output | 2 | Transmit source select |
| smp_invalid | output | 1 | Sample-invalid flag |
| tx_en | output | 1 | Transmit output enable |
| chan_stat | output | CS_BITS | Channel-status bits |

## Verification
The bench aims at the edges of the word. A short word must be dropped: a design that committed on the last partial byte would corrupt a register. A long word must keep its first 16 bits: a design that kept shifting would store the trailing ones. A device field other than 11 must leave both the registers and `sdo_oe` alone. The bench watches `sdo_oe` in every header bit period and counts the driven data periods. A readback one bit early or late shows up as a header violation or a shifted byte. It also checks reduced mode, where a design that still answered reads would raise the enable. Reads of holes, of the reserved address and of partly implemented bytes catch decode that aliases or keeps bits it should drop.

// File: rtl/ctlp_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial control register port.
package ctlp_pkg;
    localparam int FRAME_W = 16;
    localparam int HDR_W   = 8;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam logic [1:0] DEV_ID = 2'b11;

    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] A_SETUP = 5'h02;
    localparam logic [ADDR_W-1:0] A_TXS   = 5'h03;
    localparam logic [ADDR_W-1:0] A_CS0   = 5'h04;

    localparam logic [3:0] RST_CTRL  = 4'hF;
    localparam logic [2:0] RST_SETUP = 3'h0;
    localparam logic [1:0] RST_TXS   = 2'h1;
    localparam logic [7:0] RST_CS0   = 8'h04;

    typedef struct packed {
        logic [1:0]        dev;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } hdr_t;
endpackage

// File: rtl/ctlp_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes each bit is independent and is stable for several clk periods.
module ctlp_sync #(
    parameter int           W      = 3,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_V;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ctlp_shifter.sv
`timescale 1ns/1ps
// Word framing: counts and shifts host bits, raises a write strobe on a
// complete word, and serialises read data on falling serial clock edges.
// Assumes synchronised inputs and a serial clock well below clk/4.
module ctlp_shifter
    import ctlp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    input  logic              three_wire,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);

    logic               sclk_d, csn_d;
    logic [FRAME_W-1:0] sh;
    logic [DATA_W-1:0]  rsh;
    logic               rise, fall, cs_rise;
    hdr_t               hdr_now, hdr_fin;

    assign rise    = sclk_s & ~sclk_d;
    assign fall    = ~sclk_s & sclk_d;
    assign cs_rise = csn_s & ~csn_d;
    assign hdr_now = hdr_t'(sh[HDR_W-1:0]);
    assign hdr_fin = hdr_t'(sh[FRAME_W-1:FRAME_W-HDR_W]);
    assign rd_addr = hdr_now.addr;

    // Edge-detect history of the serial clock and select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
        end
    end

    // Capture up to one word of input bits while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh      <= '0;
        end else if (csn_s) begin
            bit_cnt <= '0;
        end else if (rise && bit_cnt != CNT_FULL) begin
            sh      <= {sh[FRAME_W-2:0], sdi_s};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Commit decision taken at the rising select edge.
    assign wr_stb  = cs_rise && (bit_cnt == CNT_FULL) &&
                     (hdr_fin.dev == DEV_ID) && hdr_fin.wr;
    assign wr_addr = hdr_fin.addr;
    assign wr_data = sh[DATA_W-1:0];

    // Launch read data on falling edges once the header is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_oe <= 1'b0;
            sdo    <= 1'b0;
            rsh    <= '0;
        end else if (csn_s) begin
            sdo_oe <= 1'b0;
            sdo    <= 1'b0;
        end else if (fall && bit_cnt == CNT_HDR && hdr_now.dev == DEV_ID &&
                     !hdr_now.wr && !three_wire) begin
            sdo_oe <= 1'b1;
            sdo    <= rd_data[DATA_W-1];
            rsh    <= {rd_data[DATA_W-2:0], 1'b0};
        end else if (fall && sdo_oe && bit_cnt > CNT_HDR && bit_cnt < CNT_FULL) begin
            sdo    <= rsh[DATA_W-1];
            rsh    <= {rsh[DATA_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/ctlp_regfile.sv
`timescale 1ns/1ps
// Register file with reset defaults, write decode and read mux.
// Assumes at most one write strobe per word; unknown addresses read zero.
module ctlp_regfile
    import ctlp_pkg::*;
#(
    parameter int CS_BITS = 42
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [3:0]         ctrl_q,
    output logic [2:0]         setup_q,
    output logic [1:0]         txs_q,
    output logic [CS_BITS-1:0] chan_stat
);
    localparam int CS_BYTES = (CS_BITS + 7) / 8;

    logic [7:0]            cs_arr [CS_BYTES];
    logic [8*CS_BYTES-1:0] cs_flat;

    // Control, setup and transmit-setup registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= RST_CTRL;
            setup_q <= RST_SETUP;
            txs_q   <= RST_TXS;
        end else if (wr_stb) begin
            if (wr_addr == A_CTRL)  ctrl_q  <= wr_data[3:0];
            if (wr_addr == A_SETUP) setup_q <= wr_data[2:0];
            if (wr_addr == A_TXS)   txs_q   <= wr_data[1:0];
        end
    end

    for (genvar k = 0; k < CS_BYTES; k++) begin : g_cs
        localparam int         NB   = (CS_BITS - 8*k >= 8) ? 8 : CS_BITS - 8*k;
        localparam logic [7:0] MASK = 8'((9'd1 << NB) - 9'd1);
        localparam logic [7:0] RV   = (k == 0) ? RST_CS0 : 8'h00;
        logic [7:0] byte_q;

        // One channel-status byte, keeping only implemented bits.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= RV;
            else if (wr_stb && wr_addr == A_CS0 + ADDR_W'(k))
                byte_q <= wr_data & MASK;
        end

        assign cs_arr[k]         = byte_q;
        assign cs_flat[8*k +: 8] = byte_q;
    end

    assign chan_stat = cs_flat[CS_BITS-1:0];

    // Read mux: zero for holes and the reserved address.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL)  rd_data = {4'b0, ctrl_q};
        if (rd_addr == A_SETUP) rd_data = {5'b0, setup_q};
        if (rd_addr == A_TXS)   rd_data = {6'b0, txs_q};
        for (int k = 0; k < CS_BYTES; k++)
            if (rd_addr == A_CS0 + ADDR_W'(k)) rd_data = cs_arr[k];
    end
endmodule

// File: rtl/ctlp_port.sv
`timescale 1ns/1ps
// Serial control register port, top level: synchroniser, word framing
// and register file. Assumes the host serial clock runs below clk/8.
module ctlp_port
    import ctlp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CS_BITS     = 42
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               sdi,
    output logic               sdo,
    output logic               sdo_oe,
    output logic [1:0]         link_fmt,
    output logic               pwr_up,
    output logic               core_run,
    output logic               three_wire,
    output logic [1:0]         src_sel,
    output logic               smp_invalid,
    output logic               tx_en,
    output logic [CS_BITS-1:0] chan_stat
);
    logic              csn_s, sclk_s, sdi_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_stb;
    logic [CNT_W-1:0]  bit_cnt;
    logic [3:0]        ctrl_q;
    logic [2:0]        setup_q;
    logic [1:0]        txs_q;

    ctlp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_V(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, sclk, sdi}),
        .q({csn_s, sclk_s, sdi_s})
    );

    ctlp_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(sclk_s), .csn_s(csn_s), .sdi_s(sdi_s),
        .three_wire(three_wire), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdo), .sdo_oe(sdo_oe), .bit_cnt(bit_cnt)
    );

    ctlp_regfile #(.CS_BITS(CS_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ctrl_q(ctrl_q), .setup_q(setup_q), .txs_q(txs_q),
        .chan_stat(chan_stat)
    );

    assign link_fmt    = ctrl_q[3:2];
    assign pwr_up      = ctrl_q[1];
    assign core_run    = ctrl_q[0];
    assign three_wire  = setup_q[2];
    assign src_sel     = setup_q[1:0];
    assign smp_invalid = txs_q[1];
    assign tx_en       = txs_q[0];
endmodule

// File: rtl/ctlp_port_chk.sv
`timescale 1ns/1ps
// Protocol and register checker, bound into ctlp_port.
module ctlp_port_chk #(
    parameter int CS_BITS = 42
) (
    input logic               clk,
    input logic               rst_n,
    input logic               csn_s,
    input logic               wr_stb,
    input logic [4:0]         bit_cnt,
    input logic               sdo_oe,
    input logic [1:0]         link_fmt,
    input logic               pwr_up,
    input logic               core_run,
    input logic               three_wire,
    input logic [1:0]         src_sel,
    input logic               smp_invalid,
    input logic               tx_en,
    input logic [CS_BITS-1:0] chan_stat
);
    p_commit_on_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $rose(csn_s));

    p_read_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> bit_cnt == 5'd8);

    p_idle_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !sdo_oe);

    p_no_read_3w_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !three_wire);

    p_defaults_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (link_fmt == 2'b11 && pwr_up && core_run && !three_wire &&
                          src_sel == 2'b00 && !smp_invalid && tx_en &&
                          chan_stat == {{(CS_BITS-3){1'b0}}, 3'b100}));

    p_regs_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable({link_fmt, pwr_up, core_run, three_wire, src_sel,
                             smp_invalid, tx_en, chan_stat}));
endmodule

bind ctlp_port ctlp_port_chk #(.CS_BITS(CS_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .wr_stb(wr_stb),
    .bit_cnt(bit_cnt), .sdo_oe(sdo_oe), .link_fmt(link_fmt),
    .pwr_up(pwr_up), .core_run(core_run), .three_wire(three_wire),
    .src_sel(src_sel), .smp_invalid(smp_invalid), .tx_en(tx_en),
    .chan_stat(chan_stat)
);

// File: tb/sim_ctlp_port.sv
`timescale 1ns/1ps
// Bench for ctlp_port: a vector table of words, then directed corner tests.
module sim_ctlp_port;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo, sdo_oe;
    logic [1:0]  link_fmt, src_sel;
    logic        pwr_up, core_run, three_wire, smp_invalid, tx_en;
    logic [41:0] chan_stat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    ctlp_port u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .link_fmt(link_fmt), .pwr_up(pwr_up),
        .core_run(core_run), .three_wire(three_wire), .src_sel(src_sel),
        .smp_invalid(smp_invalid), .tx_en(tx_en), .chan_stat(chan_stat)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [15:0] word;
        logic        is_rd;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{16'hC000, 1'b1, 8'h0F},  // R6 default 00h
        '{16'hC300, 1'b1, 8'h01},  // R6 default 03h
        '{16'hC400, 1'b1, 8'h04},  // R6 default 04h
        '{16'hE0A6, 1'b0, 8'h00},
        '{16'hC000, 1'b1, 8'h06},  // R8 upper bits dropped
        '{16'hE55A, 1'b0, 8'h00},
        '{16'hC500, 1'b1, 8'h5A},  // R3 full byte
        '{16'hE9FF, 1'b0, 8'h00},
        '{16'hC900, 1'b1, 8'h03},  // R8 two bits at 09h
        '{16'hE203, 1'b0, 8'h00},
        '{16'hC200, 1'b1, 8'h03},
        '{16'hE3FE, 1'b0, 8'h00},
        '{16'hC300, 1'b1, 8'h02},  // R8
        '{16'hEA77, 1'b0, 8'h00},
        '{16'hCA00, 1'b1, 8'h00},  // R7 hole
        '{16'hDF00, 1'b1, 8'h00},  // R7 top address
        '{16'hE1FF, 1'b0, 8'h00},
        '{16'hC100, 1'b1, 8'h00},  // R7 reserved
        '{16'hE881, 1'b0, 8'h00},
        '{16'hC800, 1'b1, 8'h81}   // R3
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One select period of nbits; bits past 16 are sent as ones.
    task automatic xfer(input logic [15:0] w, input int nbits,
                        output logic [7:0] rd, output int hdr_oe, output int dat_oe);
        rd = 8'h00; hdr_oe = 0; dat_oe = 0;
        cs_n = 1'b0;
        wait_clk(H);
        for (int i = 0; i < nbits; i++) begin
            sdi  = (i < 16) ? w[15-i] : 1'b1;
            sclk = 1'b0;
            wait_clk(H);
            if (i < 8) begin
                if (sdo_oe) hdr_oe++;
            end else if (i < 16) begin
                if (sdo_oe) dat_oe++;
                rd[15-i] = sdo;
            end
            sclk = 1'b1;
            wait_clk(H);
        end
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2*H);
    endtask

    task automatic rd_chk(input string req, input logic [15:0] w, input logic [7:0] exp);
        logic [7:0] rd; int h, d;
        xfer(w, 16, rd, h, d);
        chk(req, rd, exp);
        chk("R4", h, 0);
        chk("R3", d, 8);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd; int h, d;
        wait_clk(5);
        // R6: reset state at the ports
        chk("R6", {link_fmt, pwr_up, core_run, three_wire, src_sel, smp_invalid, tx_en},
            {2'b11, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1});
        chk("R6", chan_stat, 42'h4);
        chk("R4", sdo_oe, 1'b0);
        rst_n = 1'b1;
        wait_clk(3);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v].is_rd) rd_chk("R3", VEC[v].word, VEC[v].exp);
            else begin
                xfer(VEC[v].word, 16, rd, h, d);
                chk("R4", h + d, 0);
            end
        end

        // R8: field outputs after table writes
        chk("R8", {link_fmt, pwr_up, core_run}, {2'b01, 1'b1, 1'b0});
        chk("R8", {three_wire, src_sel, smp_invalid, tx_en}, {1'b0, 2'b11, 1'b1, 1'b0});
        chk("R8", chan_stat[15:8], 8'h5A);
        chk("R8", chan_stat[41:32], {2'b11, 8'h81});
        chk("R4", sdo_oe, 1'b0);

        // R1: device field mismatch on write and on read
        xfer(16'hA0FF, 16, rd, h, d);
        chk("R1", {link_fmt, pwr_up, core_run}, {2'b01, 1'b1, 1'b0});
        xfer(16'h4000, 16, rd, h, d);
        chk("R1", h + d, 0);

        // R2: short word discarded
        xfer(16'hE0FF, 12, rd, h, d);
        chk("R2", {link_fmt, pwr_up, core_run}, {2'b01, 1'b1, 1'b0});
        xfer(16'hE0FF, 15, rd, h, d);
        rd_chk("R2", 16'hC000, 8'h06);

        // R9: long word keeps first 16 bits
        xfer(16'hE00B, 20, rd, h, d);
        chk("R9", {link_fmt, pwr_up, core_run}, {2'b10, 1'b1, 1'b1});
        rd_chk("R9", 16'hC000, 8'h0B);

        // R5: write-only reduced mode
        xfer(16'hE204, 16, rd, h, d);
        chk("R5", three_wire, 1'b1);
        xfer(16'hC000, 16, rd, h, d);
        chk("R5", h + d, 0);
        xfer(16'hE50F, 16, rd, h, d);
        chk("R5", chan_stat[15:8], 8'h0F);
        xfer(16'hE200, 16, rd, h, d);
        chk("R5", three_wire, 1'b0);
        rd_chk("R5", 16'hC500, 8'h0F);

        // R10: a read does not disturb outputs
        chk("R10", chan_stat[15:0], 16'h0F04);

        // R6: reset in mid-use restores defaults
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        chk("R6", {link_fmt, pwr_up, core_run, three_wire, src_sel, smp_invalid, tx_en},
            {2'b11, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1});
        chk("R6", chan_stat, 42'h4);
        rd_chk("R6", 16'hC900, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule